// File: doc/BRIEF.md
# DRAM Strobe Timing Compliance Monitor

This block is a passive observer for an asynchronous multiplexed-address DRAM bus. It samples the active-low row strobe, column strobe, write enable and the address bus on a fast free-running clock. From the order in which the strobe edges arrive, it decides what kind of memory cycle is under way. The cycle kinds are a plain read, an early write, a further column access in page mode, a refresh driven by the row strobe alone, and a refresh where the column strobe leads the row strobe. Each cycle kind has its own set of timing rules. The monitor checks that set against interval counters that run in sample periods.

Every rule has its own error bit, which pulses for one clock when a violation is seen. One sticky summary bit records that at least one violation has occurred since reset. A classification strobe with a cycle code reports each recognised cycle. The monitor drives nothing onto the bus. It can sit beside a memory controller in a simulation model or in silicon.

All thresholds are given in nanoseconds, together with the sample period in picoseconds. They are turned into sample counts at elaboration. A minimum threshold is rounded up and a maximum threshold is rounded down, so a reported pass never relies on rounding.

Top module: `dram_strobe_monitor`

## Requirements
- R1: After reset, `errPulse`, `errAny` and `clsValid` are all 0, and `clsCode` is 0.
- R2: When the column strobe falls while the row strobe is low in a non-refresh cycle, that column access is reported. The first such fall gives code 1 (read), or code 2 (early write) when `weN` is low in the same sample. Each later fall within the same row-low period gives code 3 (page column).
- R3: A row-strobe fall seen while the column strobe is already low is reported as code 5 (refresh, column first). A row-strobe rise that ends a low period with no column fall and no refresh-first start is reported as code 4 (row-only refresh).
- R4: Error bit 0 pulses when the row strobe stays low for fewer samples than the active minimum (100 ns).
- R5: Error bit 1 pulses when the row strobe stays high for fewer samples than its precharge minimum (80 ns) between two falls. Error bit 2 pulses when two consecutive row-strobe falls are fewer samples apart than the cycle minimum (190 ns). Neither bit is checked before the first rise or fall after reset.
- R6: Error bits 3 and 4 each pulse once when the row strobe or the column strobe, respectively, has been sampled low for more than the active maximum (10,000 ns).
- R7: At a page-column fall, error bit 5 pulses when the preceding column-strobe high time is below 10 ns. Error bit 6 pulses when the fall-to-fall column period is below 60 ns.
- R8: In a refresh-first cycle, error bit 7 pulses at the column-strobe rise when that strobe was held low for fewer samples after the row strobe fell than the hold minimum (20 ns).
- R9: At the first column fall of a cycle, error bit 8 pulses when the delay from the row fall is below the row-to-column minimum (25 ns).
- R10: Error bit 9 pulses when the address differs from the value captured at the row fall before the row-hold minimum (15 ns) has elapsed. It pulses at most once per row cycle and never in a refresh-first cycle.
- R11: Every error bit is high for exactly one clock per violation. `errAny` rises with the first pulse and stays high until reset.
- R12: A minimum threshold becomes ceil(ns·1000 / SAMPLE_PS) samples. A maximum threshold becomes floor(ns·1000 / SAMPLE_PS) samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Synchronous reset, active low |
| rasN | input | 1 | Observed row strobe, active low |
| casN | input | 1 | Observed column strobe, active low |
| weN | input | 1 | Observed write enable, active low |
| addr | input | ADDR_W | Observed multiplexed address bus |
| errPulse | output | NUM_RULES | Per-rule violation pulses, bit numbers as in the requirements |
| errAny | output | 1 | Sticky violation summary |
| clsValid | output | 1 | One-clock strobe when a cycle is classified |
| clsCode | output | 3 | Cycle code: 1 read, 2 early write, 3 page column, 4 row-only refresh, 5 refresh column first |

## Verification
The bench builds the monitor with a 5 ns sample period and the default minimums, which gives thresholds of 2 to 38 samples. Every rule can therefore be driven to exactly its limit and one sample under it. The row-to-column minimum is set to 23 ns and the active maximum to 402 ns. This exercises the round-up and round-down conversion: the limits become 5 and 80 samples, so the long-pulse rules are reached within a few hundred clocks. A sweep of page-mode high times and periods, refresh hold times and row-hold windows covers both sides of each limit.

// File: rtl/dram_strobe_monitor_pkg.sv
package dram_strobe_monitor_pkg;

  localparam int NUM_RULES = 10;
  localparam int NUM_SPANS = 4;

  // span counter slots
  localparam int SPAN_RAS_PER  = 0;
  localparam int SPAN_RAS_HIGH = 1;
  localparam int SPAN_CAS_PER  = 2;
  localparam int SPAN_CAS_HIGH = 3;

  // rule bit positions
  localparam int RULE_RAS_LOW_MIN  = 0;
  localparam int RULE_RAS_HIGH_MIN = 1;
  localparam int RULE_CYCLE_MIN    = 2;
  localparam int RULE_RAS_LOW_MAX  = 3;
  localparam int RULE_CAS_LOW_MAX  = 4;
  localparam int RULE_PAGE_HIGH    = 5;
  localparam int RULE_PAGE_PERIOD  = 6;
  localparam int RULE_REF_HOLD     = 7;
  localparam int RULE_RCD_MIN      = 8;
  localparam int RULE_ROW_HOLD     = 9;

  typedef enum logic [2:0] {
    CLS_IDLE   = 3'd0,
    CLS_READ   = 3'd1,
    CLS_EWRITE = 3'd2,
    CLS_PAGE   = 3'd3,
    CLS_ROR    = 3'd4,
    CLS_CBR    = 3'd5
  } cycClass_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_SPANS-1:0] restart;
    logic                 grabRow;
  } dpStrobe_t;

endpackage

// File: rtl/dram_strobe_monitor_dp.sv
module dram_strobe_monitor_dp
  import dram_strobe_monitor_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rasN,
  input  logic                             casN,
  input  logic                             weN,
  input  logic [ADDR_W-1:0]                addr,
  input  dpStrobe_t                        strobe,
  output logic                             rasLvl,
  output logic                             rasPrev,
  output logic                             casLvl,
  output logic                             casPrev,
  output logic                             weLvl,
  output logic [NUM_SPANS-1:0][CNT_W-1:0]  spanCnt,
  output logic                             addrMoved
);

  localparam logic [CNT_W-1:0] SAT_VAL = '1;

  logic [ADDR_W-1:0] addrS1;
  logic [ADDR_W-1:0] rowLatch;

  // input sampling and one-sample history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLvl  <= 1'b1;
      rasPrev <= 1'b1;
      casLvl  <= 1'b1;
      casPrev <= 1'b1;
      weLvl   <= 1'b1;
      addrS1  <= '0;
    end else begin
      rasLvl  <= rasN;
      rasPrev <= rasLvl;
      casLvl  <= casN;
      casPrev <= casLvl;
      weLvl   <= weN;
      addrS1  <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowLatch <= '0;
    end else if (strobe.grabRow) begin
      rowLatch <= addrS1;
    end
  end

  assign addrMoved = (addrS1 != rowLatch);

  // one saturating span counter per measured interval
  for (genvar g = 0; g < NUM_SPANS; g++) begin : gSpan
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (strobe.restart[g]) begin
        q <= CNT_W'(1);
      end else if (q != SAT_VAL) begin
        q <= q + CNT_W'(1);
      end
    end
    assign spanCnt[g] = q;
  end

endmodule

// File: rtl/dram_strobe_monitor_ctl.sv
module dram_strobe_monitor_ctl
  import dram_strobe_monitor_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RAS_MIN_C = 20,
  parameter int RP_C      = 16,
  parameter int RC_C      = 38,
  parameter int ACT_C     = 2000,
  parameter int CP_C      = 2,
  parameter int PC_C      = 12,
  parameter int CHR_C     = 4,
  parameter int RCD_C     = 5,
  parameter int RAH_C     = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            rasLvl,
  input  logic                            rasPrev,
  input  logic                            casLvl,
  input  logic                            casPrev,
  input  logic                            weLvl,
  input  logic [NUM_SPANS-1:0][CNT_W-1:0] spanCnt,
  input  logic                            addrMoved,
  output dpStrobe_t                       strobe,
  output logic [NUM_RULES-1:0]            errPulse,
  output logic                            errAny,
  output logic                            clsValid,
  output cycClass_e                       clsCode
);

  localparam logic [CNT_W-1:0] RAS_MIN_L = CNT_W'(RAS_MIN_C);
  localparam logic [CNT_W-1:0] RP_L      = CNT_W'(RP_C);
  localparam logic [CNT_W-1:0] RC_L      = CNT_W'(RC_C);
  localparam logic [CNT_W-1:0] ACT_L     = CNT_W'(ACT_C);
  localparam logic [CNT_W-1:0] CP_L      = CNT_W'(CP_C);
  localparam logic [CNT_W-1:0] PC_L      = CNT_W'(PC_C);
  localparam logic [CNT_W-1:0] CHR_L     = CNT_W'(CHR_C);
  localparam logic [CNT_W-1:0] RCD_L     = CNT_W'(RCD_C);
  localparam logic [CNT_W-1:0] RAH_L     = CNT_W'(RAH_C);

  logic rasFall, rasRise, casFall, casRise;
  logic haveRasFall, haveRasRise, haveCasFall;
  logic cbrCycle, cbrHold, colSeen, rowFlagged;
  logic rasLowRun, casLowRun, colFall;
  logic [CNT_W-1:0] rasPer, rasHigh, casPer, casHigh;
  logic [NUM_RULES-1:0] errNext;
  logic clsValidNext;
  cycClass_e clsNext;

  assign rasFall = rasPrev & ~rasLvl;
  assign rasRise = ~rasPrev & rasLvl;
  assign casFall = casPrev & ~casLvl;
  assign casRise = ~casPrev & casLvl;

  assign rasPer  = spanCnt[SPAN_RAS_PER];
  assign rasHigh = spanCnt[SPAN_RAS_HIGH];
  assign casPer  = spanCnt[SPAN_CAS_PER];
  assign casHigh = spanCnt[SPAN_CAS_HIGH];

  always_comb begin
    strobe = '0;
    strobe.restart[SPAN_RAS_PER]  = rasFall;
    strobe.restart[SPAN_RAS_HIGH] = rasRise;
    strobe.restart[SPAN_CAS_PER]  = casFall;
    strobe.restart[SPAN_CAS_HIGH] = casRise;
    strobe.grabRow                = rasFall;
  end

  assign rasLowRun = haveRasFall & ~rasLvl & ~rasFall;
  assign casLowRun = haveCasFall & ~casLvl & ~casFall;
  assign colFall   = casFall & ~rasLvl & ~rasFall & haveRasFall & ~cbrCycle;

  always_comb begin
    errNext = '0;
    errNext[RULE_RAS_LOW_MIN]  = rasRise & haveRasFall & (rasPer < RAS_MIN_L);
    errNext[RULE_RAS_HIGH_MIN] = rasFall & haveRasRise & (rasHigh < RP_L);
    errNext[RULE_CYCLE_MIN]    = rasFall & haveRasFall & (rasPer < RC_L);
    errNext[RULE_RAS_LOW_MAX]  = rasLowRun & (rasPer == ACT_L);
    errNext[RULE_CAS_LOW_MAX]  = casLowRun & (casPer == ACT_L);
    errNext[RULE_PAGE_HIGH]    = colFall & colSeen & (casHigh < CP_L);
    errNext[RULE_PAGE_PERIOD]  = colFall & colSeen & (casPer < PC_L);
    errNext[RULE_REF_HOLD]     = casRise & cbrHold & (rasPer < CHR_L);
    errNext[RULE_RCD_MIN]      = colFall & ~colSeen & (rasPer < RCD_L);
    errNext[RULE_ROW_HOLD]     = rasLowRun & ~cbrCycle & ~rowFlagged & addrMoved
                                 & (rasPer < RAH_L);
  end

  always_comb begin
    clsValidNext = 1'b0;
    clsNext      = CLS_IDLE;
    if (rasFall && !casLvl) begin
      clsValidNext = 1'b1;
      clsNext      = CLS_CBR;
    end else if (colFall) begin
      clsValidNext = 1'b1;
      if (colSeen)     clsNext = CLS_PAGE;
      else if (!weLvl) clsNext = CLS_EWRITE;
      else             clsNext = CLS_READ;
    end else if (rasRise && haveRasFall && !colSeen && !cbrCycle) begin
      clsValidNext = 1'b1;
      clsNext      = CLS_ROR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveRasFall <= 1'b0;
      haveRasRise <= 1'b0;
      haveCasFall <= 1'b0;
      cbrCycle    <= 1'b0;
      cbrHold     <= 1'b0;
      colSeen     <= 1'b0;
      rowFlagged  <= 1'b0;
      errPulse    <= '0;
      errAny      <= 1'b0;
      clsValid    <= 1'b0;
      clsCode     <= CLS_IDLE;
    end else begin
      if (rasFall) haveRasFall <= 1'b1;
      if (rasRise && haveRasFall) haveRasRise <= 1'b1;
      if (casFall) haveCasFall <= 1'b1;
      if (rasFall) begin
        cbrCycle   <= ~casLvl;
        cbrHold    <= ~casLvl;
        colSeen    <= 1'b0;
        rowFlagged <= 1'b0;
      end else begin
        if (casRise) cbrHold <= 1'b0;
        if (colFall) colSeen <= 1'b1;
        if (errNext[RULE_ROW_HOLD]) rowFlagged <= 1'b1;
      end
      errPulse <= errNext;
      errAny   <= errAny | (|errNext);
      clsValid <= clsValidNext;
      clsCode  <= clsNext;
    end
  end

endmodule

// File: rtl/dram_strobe_monitor.sv
module dram_strobe_monitor
  import dram_strobe_monitor_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int SAMPLE_PS    = 5000,
  parameter int T_RAS_NS     = 100,
  parameter int T_RP_NS      = 80,
  parameter int T_RC_NS      = 190,
  parameter int T_ACT_MAX_NS = 10000,
  parameter int T_CP_NS      = 10,
  parameter int T_PC_NS      = 60,
  parameter int T_CHR_NS     = 20,
  parameter int T_RCD_NS     = 25,
  parameter int T_RAH_NS     = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_RULES-1:0] errPulse,
  output logic                 errAny,
  output logic                 clsValid,
  output logic [2:0]           clsCode
);

  // R12: minimums round up, maximum rounds down
  localparam int RAS_MIN_C = (T_RAS_NS * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int RP_C      = (T_RP_NS  * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int RC_C      = (T_RC_NS  * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int CP_C      = (T_CP_NS  * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int PC_C      = (T_PC_NS  * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int CHR_C     = (T_CHR_NS * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int RCD_C     = (T_RCD_NS * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int RAH_C     = (T_RAH_NS * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int ACT_C     = (T_ACT_MAX_NS * 1000) / SAMPLE_PS;
  localparam int TOP_C     = (ACT_C > RC_C) ? ACT_C : RC_C;
  localparam int CNT_W     = $clog2(TOP_C + 2) + 1;

  dpStrobe_t                       strobe;
  logic                            rasLvl, rasPrev, casLvl, casPrev, weLvl;
  logic [NUM_SPANS-1:0][CNT_W-1:0] spanCnt;
  logic                            addrMoved;
  cycClass_e                       clsEnum;

  dram_strobe_monitor_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .addr      (addr),
    .strobe    (strobe),
    .rasLvl    (rasLvl),
    .rasPrev   (rasPrev),
    .casLvl    (casLvl),
    .casPrev   (casPrev),
    .weLvl     (weLvl),
    .spanCnt   (spanCnt),
    .addrMoved (addrMoved)
  );

  dram_strobe_monitor_ctl #(
    .CNT_W     (CNT_W),
    .RAS_MIN_C (RAS_MIN_C),
    .RP_C      (RP_C),
    .RC_C      (RC_C),
    .ACT_C     (ACT_C),
    .CP_C      (CP_C),
    .PC_C      (PC_C),
    .CHR_C     (CHR_C),
    .RCD_C     (RCD_C),
    .RAH_C     (RAH_C)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .rasLvl    (rasLvl),
    .rasPrev   (rasPrev),
    .casLvl    (casLvl),
    .casPrev   (casPrev),
    .weLvl     (weLvl),
    .spanCnt   (spanCnt),
    .addrMoved (addrMoved),
    .strobe    (strobe),
    .errPulse  (errPulse),
    .errAny    (errAny),
    .clsValid  (clsValid),
    .clsCode   (clsEnum)
  );

  assign clsCode = clsEnum;

endmodule

// File: rtl/dram_strobe_monitor_chk.sv
module dram_strobe_monitor_chk #(
  parameter int NUM_RULES = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_RULES-1:0] errPulse,
  input logic                 errAny,
  input logic                 clsValid,
  input logic [2:0]           clsCode
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (errPulse == '0 && !errAny && !clsValid));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> errAny);

  // R11
  pulse_sets_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|errPulse) |-> errAny);

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|errPulse) |=> ((errPulse & $past(errPulse)) == '0));

  // R2 R3
  class_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    clsValid |-> (clsCode != 3'd0 && clsCode <= 3'd5));

endmodule

bind dram_strobe_monitor dram_strobe_monitor_chk #(
  .NUM_RULES (10)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .errPulse (errPulse),
  .errAny   (errAny),
  .clsValid (clsValid),
  .clsCode  (clsCode)
);

// File: tb/dram_strobe_monitor_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_monitor_tb_top;

  localparam int RULES = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasN = 1'b1;
  logic       casN = 1'b1;
  logic       weN = 1'b1;
  logic [8:0] addr = '0;
  logic [RULES-1:0] errPulse;
  logic       errAny;
  logic       clsValid;
  logic [2:0] clsCode;

  always #2.5 clk = ~clk;

  // R12: 23 ns rounds up to 5 samples, 402 ns rounds down to 80 samples
  dram_strobe_monitor #(
    .ADDR_W       (9),
    .SAMPLE_PS    (5000),
    .T_RCD_NS     (23),
    .T_ACT_MAX_NS (402)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .addr     (addr),
    .errPulse (errPulse),
    .errAny   (errAny),
    .clsValid (clsValid),
    .clsCode  (clsCode)
  );

  int checks = 0;
  int failures = 0;
  int pulseCnt [RULES];
  int baseCnt [RULES];
  int clsLog [128];
  int clsN = 0;
  int baseCls = 0;
  bit done = 1'b0;

  initial for (int r = 0; r < RULES; r++) pulseCnt[r] = 0;

  always @(negedge clk) begin
    if (rstN) begin
      for (int r = 0; r < RULES; r++) if (errPulse[r]) pulseCnt[r] = pulseCnt[r] + 1;
      if (clsValid) begin
        if (clsN < 128) clsLog[clsN] = int'(clsCode);
        clsN = clsN + 1;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    for (int r = 0; r < RULES; r++) baseCnt[r] = pulseCnt[r];
    baseCls = clsN;
  endtask

  task automatic chkRules(input string tag, input int e [RULES]);
    int badIdx = -1;
    checks++;
    for (int r = 0; r < RULES; r++)
      if (badIdx < 0 && (pulseCnt[r] - baseCnt[r]) != e[r]) badIdx = r;
    if (badIdx >= 0) begin
      failures++;
      $display("FAIL %s: rule bit %0d pulses actual=%0d expected=%0d",
               tag, badIdx, pulseCnt[badIdx] - baseCnt[badIdx], e[badIdx]);
    end
  endtask

  task automatic chkCls(input string tag, input int n, input int e [4]);
    int got = clsN - baseCls;
    int badIdx = -1;
    checks++;
    if (got != n) begin
      failures++;
      $display("FAIL %s: class events actual=%0d expected=%0d", tag, got, n);
    end else begin
      for (int i = 0; i < n; i++)
        if (badIdx < 0 && clsLog[baseCls + i] != e[i]) badIdx = i;
      if (badIdx >= 0) begin
        failures++;
        $display("FAIL %s: class[%0d] actual=%0d expected=%0d",
                 tag, badIdx, clsLog[baseCls + badIdx], e[badIdx]);
      end
    end
  endtask

  task automatic chkVal(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // row-only refresh: low for lo samples, then high for gap samples
  task automatic rorCyc(input int lo, input int gap);
    rasN = 1'b0; step(lo);
    rasN = 1'b1; step(gap);
  endtask

  // column cycle with nCol column accesses
  task automatic colCyc(input int rah, input int rcd, input int nCol, input int casLo,
                        input int casHi, input int tail, input bit wr, input int gap);
    addr = 9'h0A5; rasN = 1'b0; step(rah);
    addr = 9'h15A; step(rcd - rah);
    for (int c = 0; c < nCol; c++) begin
      weN = wr ? 1'b0 : 1'b1; casN = 1'b0; step(casLo);
      casN = 1'b1;
      if (c < nCol - 1) step(casHi);
    end
    step(tail);
    rasN = 1'b1; weN = 1'b1; step(gap);
  endtask

  // column strobe leads the row strobe; address wiggles inside the row-hold window
  task automatic cbrCyc(input int lead, input int hold, input int lo, input int gap);
    casN = 1'b0; step(lead);
    addr = 9'h033; rasN = 1'b0; step(1);
    addr = 9'h1CC; step(hold - 1);
    casN = 1'b1; step(lo - hold);
    rasN = 1'b1; step(gap);
  endtask

  initial begin
    step(4);
    // R1: reset state
    chkVal("R1 errPulse at reset", int'(errPulse), 0);
    chkVal("R1 errAny at reset", int'(errAny), 0);
    chkVal("R1 clsValid at reset", int'(clsValid), 0);
    rstN = 1'b1;
    step(20);

    // R4 R3: 20-sample row-only refresh is clean
    mark(); rorCyc(20, 40);
    chkRules("R4 ras low at limit", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R3 row-only class", 1, '{4,0,0,0});
    chkVal("R11 errAny still clear", int'(errAny), 0);

    // R4: one sample short
    mark(); rorCyc(19, 40);
    chkRules("R4 ras low short", '{1,0,0,0,0,0,0,0,0,0});
    chkVal("R11 errAny set after violation", int'(errAny), 1);

    // R2 R9 R10: clean read at rcd=5, row hold=3
    mark(); colCyc(3, 5, 1, 10, 0, 5, 1'b0, 40);
    chkRules("R9 R10 read at limits", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R2 read class", 1, '{1,0,0,0});

    // R2: early write
    mark(); colCyc(3, 5, 1, 10, 0, 5, 1'b1, 40);
    chkRules("R2 early write clean", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R2 early write class", 1, '{2,0,0,0});

    // R7: page mode at high=2, period=12
    mark(); colCyc(3, 5, 3, 10, 2, 5, 1'b0, 40);
    chkRules("R7 page at limits", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R2 page classes", 3, '{1,3,3,0});

    // R7: high=1, period=11
    mark(); colCyc(3, 5, 3, 10, 1, 5, 1'b0, 40);
    chkRules("R7 page high and period short", '{0,0,0,0,0,2,2,0,0,0});

    // R7: high=2, period=11
    mark(); colCyc(3, 5, 3, 9, 2, 5, 1'b1, 40);
    chkRules("R7 page period short", '{0,0,0,0,0,0,2,0,0,0});
    chkCls("R2 page write classes", 3, '{2,3,3,0});

    // R9 R12: rcd of 4 samples is under the rounded-up 5
    mark(); colCyc(3, 4, 1, 10, 0, 6, 1'b0, 40);
    chkRules("R9 R12 rcd short", '{0,0,0,0,0,0,0,0,1,0});

    // R10: address moves after 2 samples, flagged once
    mark(); colCyc(2, 5, 1, 10, 0, 5, 1'b0, 40);
    chkRules("R10 row hold short", '{0,0,0,0,0,0,0,0,0,1});

    // R5: precharge 15 samples, cycle 45
    mark(); rorCyc(30, 15); rorCyc(20, 40);
    chkRules("R5 precharge short", '{0,1,0,0,0,0,0,0,0,0});

    // R5: precharge 16, cycle 36
    mark(); rorCyc(20, 16); rorCyc(20, 40);
    chkRules("R5 cycle short", '{0,0,1,0,0,0,0,0,0,0});

    // R5: precharge 16, cycle 38
    mark(); rorCyc(22, 16); rorCyc(20, 40);
    chkRules("R5 cycle at limit", '{0,0,0,0,0,0,0,0,0,0});

    // R8 R3 R10: refresh with hold of 4, row wiggle ignored
    mark(); cbrCyc(2, 4, 20, 40);
    chkRules("R8 R10 refresh hold at limit", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R3 refresh class", 1, '{5,0,0,0});

    // R8: hold of 3
    mark(); cbrCyc(2, 3, 20, 40);
    chkRules("R8 refresh hold short", '{0,0,0,0,0,0,0,1,0,0});

    // R6 R12: row low 80 samples passes, 81 flags once
    mark(); rorCyc(80, 40);
    chkRules("R6 R12 ras low max at limit", '{0,0,0,0,0,0,0,0,0,0});
    mark(); rorCyc(81, 40);
    chkRules("R6 ras low max exceeded", '{0,0,0,1,0,0,0,0,0,0});

    // R6: column strobe alone low 80 then 81 samples
    mark(); casN = 1'b0; step(80); casN = 1'b1; step(40);
    chkRules("R6 cas low max at limit", '{0,0,0,0,0,0,0,0,0,0});
    chkCls("R3 no class for lone column strobe", 0, '{0,0,0,0});
    mark(); casN = 1'b0; step(81); casN = 1'b1; step(40);
    chkRules("R6 cas low max exceeded", '{0,0,0,0,1,0,0,0,0,0});

    // R11: summary stays set, reset clears it
    chkVal("R11 errAny sticky", int'(errAny), 1);
    rstN = 1'b0; step(3);
    chkVal("R11 errAny cleared by reset", int'(errAny), 0);
    chkVal("R1 errPulse after reset", int'(errPulse), 0);
    rstN = 1'b1; step(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule